// File: doc/BRIEF.md
# TDM Input Stream Delay Aligner

This block takes one serial time-division-multiplexed input stream, together with an active-low frame pulse, and recovers the bytes carried in each channel slot after shifting the frame origin by two programmable amounts. A coarse shift moves channel 0 by whole channel slots. A fine shift delays the sampling point by 0 to 31 quarter-bit steps, which absorbs skew on the serial highway. Together the two shifts let channel 0 start anywhere in the frame to within a quarter of a bit.

The block runs on a clock at four times the bit rate. Every quarter-bit sample enters a 32-entry shift line. The fine setting picks which tap of that line is read at the centre of each bit. A frame counter, restarted by every frame pulse, marks bit and slot boundaries. Each completed slot leaves the block as one byte with its realigned channel number and a single-cycle strobe. Both settings are written through a small write port. A written value applies from the first realigned channel of the frame that follows the next frame pulse.

Top module: `tdm_delay_aligner`

## Requirements
- R1: After reset, out_valid, out_byte and out_chan are all 0, and both delay settings are 0.
- R2: No byte is produced until a frame pulse (frame_n low for one clock) has been seen, and the first byte produced is realigned slot 0 of the frame that follows that pulse.
- R3: A frame has 128 slots of 8 bits, and each bit occupies 4 clocks. The first bit of a slot is bit 7 of out_byte and the last is bit 0.
- R4: With both settings at 0, the slot that starts in the clock where frame_n is sampled low is reported as channel 0, and later slots as channels 1 to 127 in order.
- R5: With channel delay C (cfg_sel = 0, cfg_wdata 0 to 127), physical slot s is reported as channel (s - C) mod 128. With C = 1, the slot that starts at the pulse becomes channel 127.
- R6: With bit delay D (cfg_sel = 1, cfg_wdata[4:0]), every bit is sampled D quarter-bits later than its nominal centre. A stream skewed by D quarter-bits is therefore recovered unchanged.
- R7: A written setting applies from the first realigned channel of the frame after the next frame pulse. Bytes of the frame that is in progress keep the old setting.
- R8: Exactly one single-cycle out_valid strobe is produced per slot, so there are 128 per frame.
- R9: The largest bit delay, 31 quarter-bits (7.75 bits), recovers the stream as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame pulse, one clock wide, at the first quarter of the frame |
| ser_in | input | 1 | Serial stream input |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_sel | input | 1 | 0 selects the channel delay, 1 selects the bit delay |
| cfg_wdata | input | 7 | Write data. The bit delay uses bits 4:0 |
| out_valid | output | 1 | One-clock strobe marking a completed byte |
| out_byte | output | 8 | Recovered byte, first bit received in bit 7 |
| out_chan | output | 7 | Realigned channel number of out_byte |

## Verification
A wrong frame counter or a wrong tap choice shows up in the first byte after the first pulse. It appears as a bit-shifted or mixed byte, or a strobe in the wrong slot, and the scoreboard catches it at the first comparison. A wrong channel offset, or a setting applied at the wrong frame, shows as a channel label that is off by a constant from the expected value, starting in the first realigned frame where the setting should take effect. A lost or extra strobe leaves items unmatched in the expected queue at the end of each two-frame run. A strobe raised before any pulse is flagged as soon as it appears.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;
  localparam int unsigned DEF_CHANS     = 128;
  localparam int unsigned DEF_SLOT_BITS = 8;
  localparam int unsigned DEF_OSR       = 4;
  localparam int unsigned DEF_TAPS      = 32;

  typedef enum logic { SEL_CHAN_DLY = 1'b0, SEL_BIT_DLY = 1'b1 } cfg_sel_e;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int unsigned CHANS     = 128,
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned OSR       = 4,
  parameter int unsigned TAPS      = 32,
  localparam int unsigned QPF = CHANS * SLOT_BITS * OSR,
  localparam int unsigned QW  = $clog2(QPF),
  localparam int unsigned OSW = $clog2(OSR),
  localparam int unsigned BIW = QW - OSW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_n,
  output logic           locked,
  output logic           samp_tick,
  output logic           frame_load,
  output logic [BIW-1:0] bit_idx
);
  // Sampling lags the raw quarter count by the deepest tap plus half a bit.
  localparam int unsigned LAT = TAPS - 1 + OSR / 2;

  logic [QW-1:0] qcnt;
  logic [QW-1:0] rcnt;

  function automatic logic [QW-1:0] realigned_quarter(input logic [QW-1:0] q);
    return q - QW'(LAT);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qcnt   <= '0;
      locked <= 1'b0;
    end else if (!frame_n) begin
      qcnt   <= '0;
      locked <= 1'b1;
    end else begin
      qcnt <= qcnt + 1'b1;
    end
  end

  always_comb begin
    rcnt       = realigned_quarter(qcnt);
    samp_tick  = locked && (rcnt[OSW-1:0] == '0);
    frame_load = locked && (rcnt == '1);
    bit_idx    = rcnt[QW-1:OSW];
  end

  AST_LOAD_APART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> !samp_tick); // R7
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |=> !samp_tick); // R3
endmodule

// File: rtl/tdm_tap_line.sv
module tdm_tap_line #(
  parameter int unsigned TAPS = 32,
  localparam int unsigned BDW = $clog2(TAPS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  input  logic [BDW-1:0] bit_dly,
  output logic           tap_bit
);
  logic [TAPS-1:0] line;

  // A larger delay reads a newer sample, since the read point is fixed.
  function automatic logic [BDW-1:0] tap_of(input logic [BDW-1:0] d);
    return BDW'(TAPS - 1) - d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) line <= '0;
    else        line <= {line[TAPS-2:0], din};
  end

  assign tap_bit = line[tap_of(bit_dly)];
endmodule

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs #(
  parameter int unsigned CHW = 7,
  parameter int unsigned BDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [CHW-1:0] cfg_wdata,
  input  logic           frame_n,
  input  logic           frame_load,
  output logic [CHW-1:0] chan_dly,
  output logic [BDW-1:0] bit_dly
);
  import tdm_align_pkg::*;

  logic [CHW-1:0] chan_wr, chan_nx;
  logic [BDW-1:0] bit_wr,  bit_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_wr  <= '0;
      bit_wr   <= '0;
      chan_nx  <= '0;
      bit_nx   <= '0;
      chan_dly <= '0;
      bit_dly  <= '0;
    end else begin
      if (cfg_we && cfg_sel == SEL_CHAN_DLY) chan_wr <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_BIT_DLY)  bit_wr  <= cfg_wdata[BDW-1:0];
      if (!frame_n) begin
        chan_nx <= chan_wr;
        bit_nx  <= bit_wr;
      end
      if (frame_load) begin
        chan_dly <= chan_nx;
        bit_dly  <= bit_nx;
      end
    end
  end

  AST_DLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(chan_dly) && $stable(bit_dly)); // R7
endmodule

// File: rtl/tdm_byte_packer.sv
module tdm_byte_packer #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned CHW       = 7,
  parameter int unsigned BIW       = 10,
  localparam int unsigned BPW = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp_tick,
  input  logic [BIW-1:0]       bit_idx,
  input  logic                 tap_bit,
  input  logic [CHW-1:0]       chan_dly,
  output logic                 byte_done,
  output logic                 out_valid,
  output logic [SLOT_BITS-1:0] out_byte,
  output logic [CHW-1:0]       out_chan
);
  logic [SLOT_BITS-2:0] acc;
  logic                 primed;
  logic [CHW-1:0]       slot;
  logic [BPW-1:0]       pos;

  function automatic logic [CHW-1:0] realign_chan(input logic [CHW-1:0] s,
                                                  input logic [CHW-1:0] c);
    return s - c;
  endfunction

  always_comb begin
    slot      = bit_idx[BIW-1:BPW];
    pos       = bit_idx[BPW-1:0];
    byte_done = samp_tick && (pos == BPW'(SLOT_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (samp_tick && bit_idx == '0) primed <= 1'b1;
      if (byte_done) begin
        out_byte  <= {acc, tap_bit};
        out_chan  <= realign_chan(slot, chan_dly);
        out_valid <= primed;
      end else if (samp_tick) begin
        acc <= {acc[SLOT_BITS-3:0], tap_bit};
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8
  AST_VALID_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(byte_done)); // R8
endmodule

// File: rtl/tdm_delay_aligner.sv
module tdm_delay_aligner #(
  parameter int unsigned CHANS     = tdm_align_pkg::DEF_CHANS,
  parameter int unsigned SLOT_BITS = tdm_align_pkg::DEF_SLOT_BITS,
  parameter int unsigned OSR       = tdm_align_pkg::DEF_OSR,
  parameter int unsigned TAPS      = tdm_align_pkg::DEF_TAPS,
  localparam int unsigned CHW = $clog2(CHANS),
  localparam int unsigned BDW = $clog2(TAPS),
  localparam int unsigned BIW = $clog2(CHANS * SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_n,
  input  logic                 ser_in,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [CHW-1:0]       cfg_wdata,
  output logic                 out_valid,
  output logic [SLOT_BITS-1:0] out_byte,
  output logic [CHW-1:0]       out_chan
);
  logic           locked, samp_tick, frame_load, tap_bit, byte_done;
  logic [BIW-1:0] bit_idx;
  logic [CHW-1:0] chan_dly;
  logic [BDW-1:0] bit_dly;

  tdm_frame_timer #(.CHANS(CHANS), .SLOT_BITS(SLOT_BITS), .OSR(OSR), .TAPS(TAPS)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .locked(locked),
    .samp_tick(samp_tick), .frame_load(frame_load), .bit_idx(bit_idx));

  tdm_tap_line #(.TAPS(TAPS)) u_taps (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .bit_dly(bit_dly), .tap_bit(tap_bit));

  tdm_cfg_regs #(.CHW(CHW), .BDW(BDW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frame_n(frame_n), .frame_load(frame_load),
    .chan_dly(chan_dly), .bit_dly(bit_dly));

  tdm_byte_packer #(.SLOT_BITS(SLOT_BITS), .CHW(CHW), .BIW(BIW)) u_pack (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .bit_idx(bit_idx),
    .tap_bit(tap_bit), .chan_dly(chan_dly), .byte_done(byte_done),
    .out_valid(out_valid), .out_byte(out_byte), .out_chan(out_chan));

  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !out_valid); // R2
  AST_NO_TICK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !byte_done); // R2
endmodule

// File: tb/sim_tdm_delay_aligner.sv
module sim_tdm_delay_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic       ser_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [6:0] out_chan;

  always #4 clk = ~clk;

  tdm_delay_aligner u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_in(ser_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_byte(out_byte), .out_chan(out_chan));

  int n_chk = 0;
  int n_fail = 0;
  int seen = 0;
  string cur_tag = "R3";
  logic [14:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int s, input int ph);
    return 8'((s * 37 + ph * 59 + 5) & 255);
  endfunction

  // Stream skewed by d quarter-bits: quarter g carries logical bit (g-d)/4.
  function automatic logic bit_at(input int g, input int d, input int ph);
    int l, lb;
    logic [7:0] b;
    l = g - d;
    if (l < 0) return 1'b0;
    lb = l / 4;
    b = byte_of(lb / 8, ph);
    return b[7 - (lb % 8)];
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 strobe with nothing expected", {out_chan, out_byte}, 0);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check({out_chan, out_byte} == e, cur_tag, {out_chan, out_byte}, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_n = 1'b1; ser_in = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 7'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_phase(input int ph, input int cd0, input int cd1, input int bd, input string tag);
    do_reset();
    cur_tag = tag;
    seen = 0;
    write_cfg(1'b0, cd0);
    write_cfg(1'b1, bd);
    for (int s = 0; s < 256; s++) begin
      int cd;
      int ch;
      cd = (s < 128) ? cd0 : cd1;
      ch = ((s % 128) - cd + 128) % 128;
      exp_q.push_back({7'(ch), byte_of(s, ph)});
    end
    for (int g = 0; g <= 8240; g++) begin
      @(negedge clk);
      frame_n = (g % 4096 == 0) ? 1'b0 : 1'b1;
      ser_in  = bit_at(g, bd, ph);
      if (g == 2000 && cd1 != cd0) begin
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 7'(cd1);
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    frame_n = 1'b1; ser_in = 1'b0;
    check(exp_q.size() == 0, {tag, " R8 bytes left unmatched"}, exp_q.size(), 0);
    check(seen == 256, "R8 strobes per two frames", seen, 256);
    exp_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(out_byte == 8'h00, "R1 byte after reset", out_byte, 0);
    check(out_chan == 7'h00, "R1 chan after reset", out_chan, 0);
    // R2: data without any frame pulse produces nothing
    seen = 0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      ser_in = bit_at(g, 0, 9);
    end
    check(seen == 0, "R2 strobes before first pulse", seen, 0);
    run_phase(0, 0, 0, 0, "R3 R4 default settings");
    run_phase(1, 1, 1, 0, "R5 channel delay 1");
    run_phase(2, 0, 0, 3, "R6 bit delay 3 quarters");
    run_phase(3, 5, 5, 31, "R9 bit delay 31 with R5 delay 5");
    run_phase(4, 127, 127, 17, "R5 R6 delay 127 and 17");
    run_phase(5, 2, 9, 6, "R7 channel delay change mid frame");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule